// File: doc/BRIEF.md
# Matrix Joypad Port Register

This block is a byte-wide, memory-mapped controller-port register. Software writes a two-bit select field that chooses which half of an eight-button vector is presented. The block then returns a four-bit active-low row value, so a pressed button reads as 0. The row value is recomputed on every clock from the stored select field, a registered copy of the button inputs and the controller-index inputs. It does not wait for a read.

A one-cycle interrupt request is raised whenever any bit of the returned row falls from 1 to 0. This covers a button press, a select change that exposes a held button, and an index change. In multi-controller mode the all-ones select returns the current controller index in place of button data. Button data is suppressed while a non-zero controller is addressed. An optional read-side filter hides a pair of opposing directions that are both pressed. The filter acts on the read value only and does not change interrupt behaviour.

Top module: `jpad_matrix_port`

## Requirements
- R1: After reset the select field is 2'b11, `rd_data` reads 0xFF and `irq` is low.
- R2: A write keeps only `wr_data[5:4]` as the new select field; the other write bits have no effect on any output. Without a write the select field holds.
- R3: `rd_data` is formed as follows: bits 7:6 read 1; bits 5:4 read the stored select; bits 3:0 read the bitwise NOT of the selected four keys, so a pressed key reads 0.
- R4: The select field chooses the keys. Select 2'b01 gives `buttons[3:0]`. Select 2'b10 gives `buttons[7:4]`. Select 2'b00 gives `buttons[3:0] | buttons[7:4]`.
- R5: With select 2'b11 the keys are the effective controller index, zero-extended to four bits. The effective index is `ctrl_idx` when `multi_en` is 1 and 0 otherwise.
- R6: While the effective controller index is non-zero, the button keys are taken as zero for selects 2'b00, 2'b01 and 2'b10.
- R7: `irq` is high for exactly one cycle after each clock edge at which the unfiltered row nibble changes with at least one bit going from 1 to 0. It is low after every other edge, including edges where bits only rise.
- R8: When `filter_en` is 1 and the select is 2'b10, the read value is adjusted pair by pair. A pair is either row bits 1:0 or row bits 3:2. A pair that would read 2'b00 reads 2'b11 instead. The filter never changes `irq`.
- R9: The delay to each output is fixed. A write at edge E updates `rd_data[5:4]` after E, and the row reflects it after E+1. Buttons sampled at E reach the row after E+1. A change on `ctrl_idx` or `multi_en` reaches the row after the first edge that follows it. `irq` rises in the same cycle as the row update it reports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write byte; bits 5:4 form the select |
| buttons | input | 8 | Active-high button states |
| ctrl_idx | input | 2 | Current controller index |
| multi_en | input | 1 | Multi-controller mode enable |
| filter_en | input | 1 | Opposing-direction filter enable |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Keypad interrupt request pulse |

## Verification
Seeded random steps vary the select, the button vector, the index and the mode flags together. Each step is compared with a bench model of the select decode and the active-low row. The model also counts the row falls, so spurious or missed interrupts are caught, including the two-step case where an index change arrives one edge ahead of a button or select change.

Directed cases cover the following:
- held buttons exposed by a select switch, which must interrupt;
- releases, which must not interrupt;
- index masking of buttons;
- opposing pairs with the filter on and off;
- the one-cycle split between the select bits and the row after a write.

// File: rtl/jpad_pkg.sv
package jpad_pkg;

    typedef enum logic [1:0] {
        SEL_BOTH  = 2'b00,
        SEL_LOW   = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_INDEX = 2'b11
    } jpad_sel_e;

    localparam jpad_sel_e SEL_RESET = SEL_INDEX;

endpackage

// File: rtl/jpad_btn_sync.sv
module jpad_btn_sync #(
    parameter int BTN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BTN_W-1:0] btn_i,
    output logic [BTN_W-1:0] btn_o
);
    typedef struct packed {
        logic [BTN_W-1:0] btn;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.btn = btn_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign btn_o = st_q.btn;
endmodule

// File: rtl/jpad_row_mux.sv
module jpad_row_mux
    import jpad_pkg::*;
#(
    parameter int BTN_W = 8,
    parameter int IDX_W = 2
) (
    input  jpad_sel_e          sel_i,
    input  logic [BTN_W-1:0]   btn_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               multi_i,
    output logic [BTN_W/2-1:0] row_o
);
    localparam int ROW_W = BTN_W / 2;

    logic [IDX_W-1:0] idx_eff;
    logic [BTN_W-1:0] btn_m;
    logic [ROW_W-1:0] keys;

    always_comb begin
        idx_eff = multi_i ? idx_i : '0;
        btn_m   = (idx_eff != '0) ? '0 : btn_i;
        unique case (sel_i)
            SEL_BOTH:  keys = btn_m[ROW_W-1:0] | btn_m[BTN_W-1:ROW_W];
            SEL_LOW:   keys = btn_m[ROW_W-1:0];
            SEL_HIGH:  keys = btn_m[BTN_W-1:ROW_W];
            default:   keys = ROW_W'(idx_eff);
        endcase
        row_o = ~keys;
    end
endmodule

// File: rtl/jpad_edge_irq.sv
module jpad_edge_irq #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row_i,
    output logic [ROW_W-1:0] row_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             irq;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.row = row_i;
        st_d.irq = |(st_q.row & ~row_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.row <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o = st_q.row;
    assign irq_o = st_q.irq;

    p_irq_needs_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|($past(row_o) & ~row_o)));

    p_fall_gives_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(row_o) & ~row_o)) |-> irq_o);
endmodule

// File: rtl/jpad_read_fmt.sv
module jpad_read_fmt
    import jpad_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int DATA_W = 8
) (
    input  jpad_sel_e         sel_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              filter_i,
    output logic [DATA_W-1:0] rd_o
);
    localparam int PAIRS = ROW_W / 2;

    logic             filt_on;
    logic [ROW_W-1:0] row_f;

    assign filt_on = filter_i && (sel_i == SEL_HIGH);

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign row_f[2*g+1:2*g] = (filt_on && row_i[2*g+1:2*g] == 2'b00)
                                  ? 2'b11 : row_i[2*g+1:2*g];
    end

    always_comb begin
        rd_o                   = '1;
        rd_o[ROW_W+1:ROW_W]    = sel_i;
        rd_o[ROW_W-1:0]        = row_f;
    end
endmodule

// File: rtl/jpad_matrix_port.sv
module jpad_matrix_port
    import jpad_pkg::*;
#(
    parameter int BTN_W  = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BTN_W-1:0]  buttons,
    input  logic [IDX_W-1:0]  ctrl_idx,
    input  logic              multi_en,
    input  logic              filter_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int ROW_W   = BTN_W / 2;
    localparam int SEL_LSB = ROW_W;

    typedef struct packed {
        jpad_sel_e sel;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [BTN_W-1:0] btn_q;
    logic [ROW_W-1:0] row_raw;
    logic [ROW_W-1:0] row_q;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DATA_W-1:SEL_LSB+2], wr_data[SEL_LSB-1:0]};

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.sel = jpad_sel_e'(wr_data[SEL_LSB+1:SEL_LSB]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sel <= SEL_RESET;
        else        st_q     <= st_d;
    end

    jpad_btn_sync #(.BTN_W(BTN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_i (buttons),
        .btn_o (btn_q)
    );

    jpad_row_mux #(.BTN_W(BTN_W), .IDX_W(IDX_W)) u_mux (
        .sel_i   (st_q.sel),
        .btn_i   (btn_q),
        .idx_i   (ctrl_idx),
        .multi_i (multi_en),
        .row_o   (row_raw)
    );

    jpad_edge_irq #(.ROW_W(ROW_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .row_i (row_raw),
        .row_o (row_q),
        .irq_o (irq)
    );

    jpad_read_fmt #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_fmt (
        .sel_i    (st_q.sel),
        .row_i    (row_q),
        .filter_i (filter_en),
        .rd_o     (rd_data)
    );

    p_sel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[SEL_LSB+1:SEL_LSB] == $past(wr_data[SEL_LSB+1:SEL_LSB]));

    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.sel));

    p_idx_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_en && ctrl_idx != '0 && st_q.sel != SEL_INDEX) |-> row_raw == '1);

    p_filter_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_en && rd_data[SEL_LSB+1:SEL_LSB] == SEL_HIGH)
        |-> (rd_data[1:0] != 2'b00 && rd_data[3:2] != 2'b00));
endmodule

// File: tb/tb_jpad_matrix_port.sv
module tb_jpad_matrix_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] buttons = '0;
    logic [1:0] ctrl_idx = '0;
    logic       multi_en = 1'b0;
    logic       filter_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;

    logic [1:0] m_sel = 2'b11;
    logic [7:0] m_btn = '0;
    logic [1:0] m_idx = '0;
    logic       m_multi = 1'b0;

    always #10 clk = ~clk;

    jpad_matrix_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .buttons(buttons), .ctrl_idx(ctrl_idx), .multi_en(multi_en),
        .filter_en(filter_en), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [3:0] nib(input logic [1:0] s, input logic [7:0] b,
                                       input logic [1:0] ix, input logic mu);
        logic [1:0] e;
        logic [7:0] bb;
        logic [3:0] k;
        e  = mu ? ix : 2'b00;
        bb = (e != 2'b00) ? 8'h00 : b;
        case (s)
            2'b00:   k = bb[3:0] | bb[7:4];
            2'b01:   k = bb[3:0];
            2'b10:   k = bb[7:4];
            default: k = {2'b00, e};
        endcase
        return ~k;
    endfunction

    function automatic logic [3:0] filt(input logic [1:0] s, input logic [3:0] n, input logic f);
        logic [3:0] r;
        r = n;
        if (f && s == 2'b10) begin
            if (r[1:0] == 2'b00) r[1:0] = 2'b11;
            if (r[3:2] == 2'b00) r[3:2] = 2'b11;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] wd, input logic [7:0] b,
                        input logic [1:0] ix, input bit mu, input bit fe, input string tag);
        logic [3:0] old_n, mid_n, fin_n;
        logic [1:0] ns;
        logic [2:0] exp_i, act_i;
        old_n = nib(m_sel, m_btn, m_idx, m_multi);
        mid_n = nib(m_sel, m_btn, ix, mu);
        ns    = wr ? wd[5:4] : m_sel;
        fin_n = nib(ns, b, ix, mu);
        exp_i = {1'b0, |(mid_n & ~fin_n), |(old_n & ~mid_n)};
        wr_en = wr; wr_data = wd; buttons = b; ctrl_idx = ix; multi_en = mu; filter_en = fe;
        act_i = '0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) wr_en = 1'b0;
            act_i[k] = irq;
        end
        chk(tag, rd_data, {2'b11, ns, filt(ns, fin_n, fe)});
        chk("R7 irq", {5'b0, act_i}, {5'b0, exp_i});
        m_sel = ns; m_btn = b; m_idx = ix; m_multi = mu;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset rd", rd_data, 8'hFF);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", rd_data, 8'hFF);

        // R2 / R4: low half, ignored write bits set
        step(1, 8'hDF, 8'h00, 0, 0, 0, "R2 write low");
        step(0, 8'h00, 8'h05, 0, 0, 0, "R4 low press");
        step(1, 8'hEF, 8'h05, 0, 0, 0, "R2 ignored bits");
        step(0, 8'h00, 8'h00, 0, 0, 0, "R7 release no irq");
        // R4 high half / both
        step(1, 8'h20, 8'h90, 0, 0, 0, "R4 high");
        step(1, 8'h00, 8'h90, 0, 0, 0, "R4 both");
        step(0, 8'h00, 8'h12, 0, 0, 0, "R3 both or");
        // R5 index select
        step(1, 8'h30, 8'hFF, 0, 0, 0, "R5 index off");
        step(0, 8'h00, 8'hFF, 2'd3, 1, 0, "R5 index 3");
        step(0, 8'h00, 8'hFF, 2'd0, 0, 0, "R5 multi off");
        // R6 masking
        step(1, 8'h10, 8'h0F, 2'd1, 1, 0, "R6 masked");
        step(0, 8'h00, 8'h0F, 2'd0, 1, 0, "R6 unmasked");
        // R8 filter
        step(1, 8'h20, 8'hF0, 0, 0, 1, "R8 filter both pairs");
        step(0, 8'h00, 8'h30, 0, 0, 1, "R8 filter one pair");
        step(0, 8'h00, 8'h30, 0, 0, 0, "R8 filter off");
        step(0, 8'h00, 8'h50, 0, 0, 1, "R8 no opposing");

        // R9 latency: write + buttons
        step(1, 8'h10, 8'h01, 0, 0, 0, "R9 setup");
        wr_en = 1'b1; wr_data = 8'h20; buttons = 8'h20;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R9 sel first", rd_data, 8'hEE);
        @(posedge clk); @(negedge clk);
        chk("R9 row second", rd_data, 8'hED);
        m_sel = 2'b10; m_btn = 8'h20;
        // R9 latency: index path
        step(1, 8'h30, 8'h20, 0, 1, 0, "R9 idx setup");
        ctrl_idx = 2'd2;
        @(posedge clk); @(negedge clk);
        chk("R9 idx one edge", rd_data, 8'hFD);
        chk("R9 idx irq", {7'b0, irq}, 8'h01);
        m_idx = 2'd2; m_multi = 1'b1;

        for (int i = 0; i < 300; i++) begin
            logic [7:0] wd, b;
            logic [1:0] ix;
            bit wr, mu, fe;
            string tg;
            wr = bit'($urandom_range(0, 1));
            wd = 8'($urandom);
            b  = 8'($urandom);
            ix = 2'($urandom);
            mu = ($urandom_range(0, 3) == 0);
            fe = bit'($urandom_range(0, 1));
            if ((wr ? wd[5:4] : m_sel) == 2'b11)       tg = "R5 rand";
            else if (mu && ix != 0)                    tg = "R6 rand";
            else if (fe && (wr ? wd[5:4] : m_sel) == 2) tg = "R8 rand";
            else                                       tg = "R4 rand";
            step(wr, wd, b, ix, mu, fe, tg);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule